// File: doc/BRIEF.md
# SATA Bridge Bring-Up Sequencer

This block brings up two PATA-to-SATA bridge adapters in hardware, one at a time. A request names one bridge and an operation: start, reset or stop. For a start, the sequencer turns on the bridge's peripheral clock enable and lets the clock settle. It then loads the bridge control word and waits for the bridge to settle. After that it samples the bridge's PHY-ready bit at a fixed interval. It stops sampling at the first sample that shows the bit set, or when a bounded window runs out. The outcome is reported as a per-bridge online or failed flag. If a start fails, the clock enable of that bridge is taken away again.

A reset request pulses the bridge's reset line and waits for the bridge to settle. It then runs the same control-word and polling steps. A stop request only clears the clock enable of the bridge it names. A 3-bit routing mode input has two jobs. It decides whether a bridge's control word carries the slave-enable bit. It also tells each ATA controller whether a bridge is wired to it. Mode values outside 0..3 are refused.

All waits are counted in millisecond ticks, and the number of clock cycles per tick is a parameter. Requests use a valid/ready handshake, and ready is low while a sequence is running.

Top module: `sata_bringup_seq`

## Requirements
- R1: A written control word always has bit 0 (bridge enable) and bit 4 (hotplug detect) set. Its only other bit that may be set is bit 1. Every other bit is zero, so the value is 0x11 or 0x13. After reset both words read 0.
- R2: Bit 1 (slave enable) is set in bridge 0's word only when the latched routing mode is 2, and in bridge 1's word only when the latched mode is 3.
- R3: A start request (op 0) raises that bridge's clock enable in the cycle after acceptance. The control word is written CLK_SETTLE_MS milliseconds later, one cycle after that wait ends.
- R4: After the control word is written, the block waits CTRL_SETTLE_MS ms. It then samples the bridge-ready input once every POLL_MS ms. The first sample that sees it high sets online. Online and failed for that bridge are cleared when the request is accepted.
- R5: If ceil(TIMEOUT_MS/POLL_MS) samples in a row see the ready input low, the failed flag is set and online stays low.
- R6: A failed start clears that bridge's clock enable. A failed reset sequence leaves the clock enable as it was.
- R7: A reset request (op 1) drives that bridge's reset high for RST_PULSE_CYC cycles. After RST_SETTLE_MS ms it writes the control word and then continues as in R4 and R5.
- R8: A stop request (op 2) clears only the named bridge's clock enable. The other bridge's enable is left unchanged.
- R9: ataBridgeEn[0] is low when the mode is 2 or the mode is 4..7. ataBridgeEn[1] is low when the mode is 3 or the mode is 4..7. Otherwise each bit is high.
- R10: A request whose routing mode is 4..7 is dropped. It sets modeErr, changes no clock enable, reset or control word, and starts no sequence. modeErr clears on the next accepted request with a valid mode.
- R11: reqReady is low from acceptance until the sequence reports its outcome. Only one bridge is sequenced at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request accepted this cycle if valid |
| reqOp | input | 2 | 0 start, 1 reset, 2 stop, 3 no operation |
| reqBridge | input | 1 | Bridge addressed by the request |
| muxMode | input | 3 | Routing mode, valid values 0..3 |
| bridgeReady | input | 2 | PHY-ready status bit of each bridge |
| clkEn | output | 2 | Per-bridge peripheral clock enable |
| bridgeRst | output | 2 | Per-bridge reset pulse |
| ctrlWord0 | output | CTRL_W | Control word of bridge 0 |
| ctrlWord1 | output | CTRL_W | Control word of bridge 1 |
| online | output | 2 | Bridge came online |
| failed | output | 2 | Bridge did not come online within the window |
| modeErr | output | 1 | Last request carried an illegal routing mode |
| ataBridgeEn | output | 2 | Per-ATA-controller bridge present indication |

## Verification
Every legal routing mode is swept with start requests on both bridges and ready held high. This separates the four slave-bit patterns and fixes the exact latency of a first-sample success. A ready that rises between samples checks that the result lands on the third sample and not on an earlier one. Ready held low checks the sample count of the failure window and the loss of the clock enable. Reset requests, both failing and succeeding after a successful start, show the pulse width and that the clock enable is untouched on failure. Stop and illegal-mode requests with both clocks on show that only the named bridge, or nothing at all, changes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_RESET = 2'd1,
    OP_STOP  = 2'd2,
    OP_NONE  = 2'd3
  } sbs_op_e;

  typedef enum logic [1:0] {
    W_CLK  = 2'd0,
    W_CTRL = 2'd1,
    W_RST  = 2'd2,
    W_POLL = 2'd3
  } sbs_wait_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic      load;
    sbs_wait_e waitSel;
    logic      sel;
    logic      clkOn;
    logic      clkOff;
    logic      rstOn;
    logic      writeCtrl;
    logic      clrResult;
    logic      latchMode;
    logic      pollClr;
    logic      pollInc;
    logic      markOnline;
    logic      markFailed;
  } sbs_strobe_t;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        reqBridge,
  input  logic [2:0]  muxMode,
  input  logic        timerDone,
  input  logic        rstActive,
  input  logic        phyReady,
  input  logic        pollLast,
  output logic        reqReady,
  output logic        modeErr,
  output sbs_strobe_t strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_CLK, S_RPULSE, S_RWAIT, S_CTRL, S_POLL
  } state_e;

  state_e stateQ, stateD;
  logic   curBridge;
  logic   curIsStart;
  logic   modeBad;

  assign reqReady = (stateQ == S_IDLE);
  assign modeBad  = muxMode[2];

  always_comb begin
    strb    = '0;
    strb.sel = curBridge;
    stateD  = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        strb.sel = reqBridge;
        if (reqValid && !modeBad) begin
          case (sbs_op_e'(reqOp))
            OP_START: begin
              strb.clkOn     = 1'b1;
              strb.clrResult = 1'b1;
              strb.latchMode = 1'b1;
              strb.load      = 1'b1;
              strb.waitSel   = W_CLK;
              stateD         = S_CLK;
            end
            OP_RESET: begin
              strb.rstOn     = 1'b1;
              strb.clrResult = 1'b1;
              strb.latchMode = 1'b1;
              stateD         = S_RPULSE;
            end
            OP_STOP: strb.clkOff = 1'b1;
            default: ;
          endcase
        end
      end
      S_CLK, S_RWAIT: begin
        if (timerDone) begin
          strb.writeCtrl = 1'b1;
          strb.load      = 1'b1;
          strb.waitSel   = W_CTRL;
          stateD         = S_CTRL;
        end
      end
      S_RPULSE: begin
        if (!rstActive) begin
          strb.load    = 1'b1;
          strb.waitSel = W_RST;
          stateD       = S_RWAIT;
        end
      end
      S_CTRL: begin
        if (timerDone) begin
          strb.pollClr = 1'b1;
          strb.load    = 1'b1;
          strb.waitSel = W_POLL;
          stateD       = S_POLL;
        end
      end
      S_POLL: begin
        if (timerDone) begin
          if (phyReady) begin
            strb.markOnline = 1'b1;
            stateD          = S_IDLE;
          end else if (pollLast) begin
            strb.markFailed = 1'b1;
            strb.clkOff     = curIsStart;
            stateD          = S_IDLE;
          end else begin
            strb.pollInc = 1'b1;
            strb.load    = 1'b1;
            strb.waitSel = W_POLL;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      curBridge  <= 1'b0;
      curIsStart <= 1'b0;
      modeErr    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (reqReady && reqValid) begin
        modeErr <= modeBad;
        if (!modeBad) begin
          curBridge  <= reqBridge;
          curIsStart <= (sbs_op_e'(reqOp) == OP_START);
        end
      end
    end
  end

endmodule

// File: rtl/sbs_dpath.sv
module sbs_dpath
  import sbs_pkg::*;
#(
  parameter int CYC_PER_MS     = 100000,
  parameter int CLK_SETTLE_MS  = 10,
  parameter int CTRL_SETTLE_MS = 10,
  parameter int RST_SETTLE_MS  = 10,
  parameter int POLL_MS        = 100,
  parameter int TIMEOUT_MS     = 1000,
  parameter int RST_PULSE_CYC  = 16,
  parameter int CTRL_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbs_strobe_t       strb,
  input  logic [1:0]        modeIn,
  input  logic [1:0]        bridgeReady,
  output logic              phyReady,
  output logic              timerDone,
  output logic              rstActive,
  output logic              pollLast,
  output logic [1:0]        clkEn,
  output logic [1:0]        bridgeRst,
  output logic [CTRL_W-1:0] ctrlWord0,
  output logic [CTRL_W-1:0] ctrlWord1,
  output logic [1:0]        online,
  output logic [1:0]        failed
);

  localparam int NUM_BR    = 2;
  localparam int NUM_POLLS = (TIMEOUT_MS + POLL_MS - 1) / POLL_MS;
  localparam int MAX_A     = (CLK_SETTLE_MS > CTRL_SETTLE_MS) ? CLK_SETTLE_MS : CTRL_SETTLE_MS;
  localparam int MAX_B     = (RST_SETTLE_MS > POLL_MS) ? RST_SETTLE_MS : POLL_MS;
  localparam int MAX_MS    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MS_W      = $clog2(MAX_MS + 1);
  localparam int PRE_W     = $clog2(CYC_PER_MS + 1);
  localparam int POLL_W    = $clog2(NUM_POLLS + 1);
  localparam int RCNT_W    = $clog2(RST_PULSE_CYC + 1);
  localparam int EN_BIT    = 0;
  localparam int SLV_BIT   = 1;
  localparam int HP_BIT    = 4;
  localparam logic [CTRL_W-1:0] BASE_WORD =
    (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << HP_BIT);

  logic [MS_W-1:0]   msLeft;
  logic [PRE_W-1:0]  preCnt;
  logic [MS_W-1:0]   loadVal;
  logic [POLL_W-1:0] pollCnt;
  logic [RCNT_W-1:0] rstCnt;
  logic [1:0]        modeQ;

  logic              clkEnQ  [NUM_BR];
  logic              rstQ    [NUM_BR];
  logic              onlineQ [NUM_BR];
  logic              failedQ [NUM_BR];
  logic [CTRL_W-1:0] wordQ   [NUM_BR];

  always_comb begin
    case (strb.waitSel)
      W_CLK:   loadVal = MS_W'(CLK_SETTLE_MS);
      W_CTRL:  loadVal = MS_W'(CTRL_SETTLE_MS);
      W_RST:   loadVal = MS_W'(RST_SETTLE_MS);
      default: loadVal = MS_W'(POLL_MS);
    endcase
  end

  assign timerDone = (msLeft == '0);
  assign pollLast  = (pollCnt == POLL_W'(NUM_POLLS - 1));
  assign phyReady  = strb.sel ? bridgeReady[1] : bridgeReady[0];
  assign rstActive = rstQ[0] | rstQ[1];

  // millisecond tick prescaler and millisecond down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msLeft  <= '0;
      preCnt  <= '0;
      pollCnt <= '0;
      rstCnt  <= '0;
      modeQ   <= '0;
    end else begin
      if (strb.load) begin
        msLeft <= loadVal;
        preCnt <= '0;
      end else if (msLeft != '0) begin
        if (preCnt == PRE_W'(CYC_PER_MS - 1)) begin
          preCnt <= '0;
          msLeft <= msLeft - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      if (strb.pollClr)      pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (strb.rstOn)                         rstCnt <= RCNT_W'(RST_PULSE_CYC - 1);
      else if (rstActive && rstCnt != '0)     rstCnt <= rstCnt - 1'b1;
      if (strb.latchMode) modeQ <= modeIn;
    end
  end

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    logic hit;
    logic slave;
    assign hit   = (strb.sel == 1'(b));
    assign slave = (modeQ == 2'(2 + b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkEnQ[b]  <= 1'b0;
        rstQ[b]    <= 1'b0;
        onlineQ[b] <= 1'b0;
        failedQ[b] <= 1'b0;
        wordQ[b]   <= '0;
      end else begin
        if (hit && strb.clkOn)       clkEnQ[b] <= 1'b1;
        else if (hit && strb.clkOff) clkEnQ[b] <= 1'b0;
        if (hit && strb.rstOn)             rstQ[b] <= 1'b1;
        else if (rstQ[b] && rstCnt == '0)  rstQ[b] <= 1'b0;
        if (hit && strb.writeCtrl)
          wordQ[b] <= BASE_WORD | (slave ? (CTRL_W'(1) << SLV_BIT) : '0);
        if (hit && strb.clrResult) begin
          onlineQ[b] <= 1'b0;
          failedQ[b] <= 1'b0;
        end else begin
          if (hit && strb.markOnline) onlineQ[b] <= 1'b1;
          if (hit && strb.markFailed) failedQ[b] <= 1'b1;
        end
      end
    end

    assign clkEn[b]     = clkEnQ[b];
    assign bridgeRst[b] = rstQ[b];
    assign online[b]    = onlineQ[b];
    assign failed[b]    = failedQ[b];
  end

  assign ctrlWord0 = wordQ[0];
  assign ctrlWord1 = wordQ[1];

endmodule

// File: rtl/sata_bringup_seq.sv
module sata_bringup_seq
  import sbs_pkg::*;
#(
  parameter int CYC_PER_MS     = 100000,
  parameter int CLK_SETTLE_MS  = 10,
  parameter int CTRL_SETTLE_MS = 10,
  parameter int RST_SETTLE_MS  = 10,
  parameter int POLL_MS        = 100,
  parameter int TIMEOUT_MS     = 1000,
  parameter int RST_PULSE_CYC  = 16,
  parameter int CTRL_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic              reqBridge,
  input  logic [2:0]        muxMode,
  input  logic [1:0]        bridgeReady,
  output logic [1:0]        clkEn,
  output logic [1:0]        bridgeRst,
  output logic [CTRL_W-1:0] ctrlWord0,
  output logic [CTRL_W-1:0] ctrlWord1,
  output logic [1:0]        online,
  output logic [1:0]        failed,
  output logic              modeErr,
  output logic [1:0]        ataBridgeEn
);

  sbs_strobe_t strb;
  logic timerDone, rstActive, phyReady, pollLast;

  // ATA0 has no bridge in mode 2, ATA1 none in mode 3
  assign ataBridgeEn[0] = !muxMode[2] && (muxMode[1:0] != 2'd2);
  assign ataBridgeEn[1] = !muxMode[2] && (muxMode[1:0] != 2'd3);

  sbs_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqBridge (reqBridge),
    .muxMode   (muxMode),
    .timerDone (timerDone),
    .rstActive (rstActive),
    .phyReady  (phyReady),
    .pollLast  (pollLast),
    .reqReady  (reqReady),
    .modeErr   (modeErr),
    .strb      (strb)
  );

  sbs_dpath #(
    .CYC_PER_MS     (CYC_PER_MS),
    .CLK_SETTLE_MS  (CLK_SETTLE_MS),
    .CTRL_SETTLE_MS (CTRL_SETTLE_MS),
    .RST_SETTLE_MS  (RST_SETTLE_MS),
    .POLL_MS        (POLL_MS),
    .TIMEOUT_MS     (TIMEOUT_MS),
    .RST_PULSE_CYC  (RST_PULSE_CYC),
    .CTRL_W         (CTRL_W)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .modeIn      (muxMode[1:0]),
    .bridgeReady (bridgeReady),
    .phyReady    (phyReady),
    .timerDone   (timerDone),
    .rstActive   (rstActive),
    .pollLast    (pollLast),
    .clkEn       (clkEn),
    .bridgeRst   (bridgeRst),
    .ctrlWord0   (ctrlWord0),
    .ctrlWord1   (ctrlWord1),
    .online      (online),
    .failed      (failed)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqOp,
  input logic              reqBridge,
  input logic [2:0]        muxMode,
  input logic [1:0]        bridgeReady,
  input logic [1:0]        clkEn,
  input logic [1:0]        bridgeRst,
  input logic [CTRL_W-1:0] ctrlWord0,
  input logic [CTRL_W-1:0] ctrlWord1,
  input logic [1:0]        online,
  input logic [1:0]        failed,
  input logic              modeErr,
  input logic [1:0]        ataBridgeEn
);

  localparam logic [CTRL_W-1:0] FREE_MASK = ~CTRL_W'('h13);

  assert_word0_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord0 != '0) |-> (ctrlWord0[0] && ctrlWord0[4] && ((ctrlWord0 & FREE_MASK) == '0)));
  assert_word1_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord1 != '0) |-> (ctrlWord1[0] && ctrlWord1[4] && ((ctrlWord1 & FREE_MASK) == '0)));

  assert_online0_sampled_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(online[0]) |-> $past(bridgeReady[0]));
  assert_online1_sampled_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(online[1]) |-> $past(bridgeReady[1]));
  assert_result_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (online & failed) == 2'b00);

  assert_rst_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeRst != 2'b00) |-> !reqReady);
  assert_rst_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bridgeRst));

  assert_stop_other_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !muxMode[2] && reqOp == 2'd2)
      |=> (clkEn[!$past(reqBridge)] == $past(clkEn[!reqBridge])) && !clkEn[$past(reqBridge)]);

  assert_ata0_R9: assert property (@(posedge clk) disable iff (!rstN)
    (muxMode == 3'd2 || muxMode[2]) |-> !ataBridgeEn[0]);
  assert_ata1_R9: assert property (@(posedge clk) disable iff (!rstN)
    (muxMode == 3'd3 || muxMode[2]) |-> !ataBridgeEn[1]);

  assert_mode_err_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeErr) |-> $past(reqValid && reqReady && muxMode[2]));
  assert_bad_mode_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && muxMode[2]) |=> (reqReady && $stable(clkEn) && $stable(bridgeRst)));

endmodule

bind sata_bringup_seq sbs_checker #(.CTRL_W(CTRL_W)) i_sbs_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqOp       (reqOp),
  .reqBridge   (reqBridge),
  .muxMode     (muxMode),
  .bridgeReady (bridgeReady),
  .clkEn       (clkEn),
  .bridgeRst   (bridgeRst),
  .ctrlWord0   (ctrlWord0),
  .ctrlWord1   (ctrlWord1),
  .online      (online),
  .failed      (failed),
  .modeErr     (modeErr),
  .ataBridgeEn (ataBridgeEn)
);

// File: tb/test_sata_bringup_seq.sv
`timescale 1ns/1ps
module test_sata_bringup_seq;

  localparam int C   = 4;   // cycles per ms
  localparam int S1  = 2;   // clock settle ms
  localparam int S2  = 2;   // control settle ms
  localparam int RS  = 2;   // reset settle ms
  localparam int PM  = 3;   // poll interval ms
  localparam int TO  = 12;  // timeout ms
  localparam int RP  = 3;   // reset pulse cycles
  localparam int NP  = (TO + PM - 1) / PM;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqOp = 2'd0;
  logic          reqBridge = 1'b0;
  logic [2:0]    muxMode = 3'd0;
  logic [1:0]    bridgeReady = 2'b00;
  logic [1:0]    clkEn, bridgeRst, online, failed, ataBridgeEn;
  logic [CW-1:0] ctrlWord0, ctrlWord1;
  logic          modeErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sata_bringup_seq #(
    .CYC_PER_MS(C), .CLK_SETTLE_MS(S1), .CTRL_SETTLE_MS(S2), .RST_SETTLE_MS(RS),
    .POLL_MS(PM), .TIMEOUT_MS(TO), .RST_PULSE_CYC(RP), .CTRL_W(CW)
  ) i_sata_bringup_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqBridge(reqBridge), .muxMode(muxMode), .bridgeReady(bridgeReady), .clkEn(clkEn),
    .bridgeRst(bridgeRst), .ctrlWord0(ctrlWord0), .ctrlWord1(ctrlWord1), .online(online),
    .failed(failed), .modeErr(modeErr), .ataBridgeEn(ataBridgeEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wordOf(input int b);
    return (b == 1) ? int'(ctrlWord1) : int'(ctrlWord0);
  endfunction

  function automatic int expWord(input int mode, input int b);
    return 'h11 | ((mode == 2 + b) ? 2 : 0);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0; bridgeReady = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic issue(input int op, input int br, input int mode);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqBridge = 1'(br); muxMode = 3'(mode);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // op 0 start / 1 reset; readyAt: -1 never, 0 from the start, else cycle
  task automatic runSeq(input int op, input int br, input int mode, input int readyAt,
                        input bit expOn, input int expK, input bit chkWrite);
    int n = 0;
    int rstHigh = 0;
    int wrAt = -1;
    int readyLeaks = 0;
    int expL;
    bit preClk;
    preClk = clkEn[br];
    bridgeReady[br] = (readyAt == 0);
    bridgeReady[1-br] = 1'b0;
    issue(op, br, mode);
    if (op == 0) chk("R3 clock enable after start", int'(clkEn[br]), 1);
    else         chk("R7 reset asserted after request", int'(bridgeRst[br]), 1);
    chk("R4 results cleared on acceptance", int'(online[br] | failed[br]), 0);
    if (bridgeRst[br]) rstHigh++;
    while (!(online[br] || failed[br]) && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (readyAt > 0 && n == readyAt) bridgeReady[br] = 1'b1;
      if (bridgeRst[br]) rstHigh++;
      if (wrAt < 0 && wordOf(br) != 0) wrAt = n;
      if (reqReady && !(online[br] || failed[br])) readyLeaks++;
    end
    if (op == 0) expL = (S1 + S2) * C + 2 + expK * (PM * C + 1);
    else         expL = RP + 3 + (RS + S2) * C + expK * (PM * C + 1);
    chk(expOn ? "R4 latency to online" : "R5 latency to failed", n, expL);
    chk("R4 online flag", int'(online[br]), int'(expOn));
    chk("R5 failed flag", int'(failed[br]), int'(!expOn));
    chk("R11 ready low while busy", readyLeaks, 0);
    chk("R11 ready back after outcome", int'(reqReady), 1);
    chk("R2 control word value", wordOf(br), expWord(mode, br));
    if (op == 1) chk("R7 reset pulse width", rstHigh, RP);
    if (chkWrite && op == 0) chk("R3 control write time", wrAt, S1 * C + 1);
    if (op == 0 && !expOn) chk("R6 clock dropped on failed start", int'(clkEn[br]), 0);
    if (op == 1 && !expOn) chk("R6 clock kept on failed reset", int'(clkEn[br]), int'(preClk));
    if (op == 0 && expOn) chk("R3 clock kept on success", int'(clkEn[br]), 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // reset state
    chk("R11 ready after reset", int'(reqReady), 1);
    chk("R3 clock enables after reset", int'(clkEn), 0);
    chk("R7 resets idle after reset", int'(bridgeRst), 0);
    chk("R1 word0 after reset", int'(ctrlWord0), 0);
    chk("R1 word1 after reset", int'(ctrlWord1), 0);
    chk("R4 flags after reset", int'({online, failed}), 0);
    chk("R10 error after reset", int'(modeErr), 0);

    // R9 sweep of routing modes
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      muxMode = 3'(m);
      #1;
      chk("R9 ata0 bridge present", int'(ataBridgeEn[0]), int'(m < 4 && m != 2));
      chk("R9 ata1 bridge present", int'(ataBridgeEn[1]), int'(m < 4 && m != 3));
    end

    // R1 R2 R3 R4: every legal mode, both bridges, ready at first sample
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        doReset();
        runSeq(0, b, m, 0, 1'b1, 1, 1'b1);
        chk("R1 other word untouched", wordOf(1 - b), 0);
        chk("R8 other clock untouched", int'(clkEn[1 - b]), 0);
      end
    end

    // R4: ready appears between samples, lands on third sample
    doReset();
    runSeq(0, 1, 0, 46, 1'b1, 3, 1'b1);

    // R5 R6: never ready on a start
    doReset();
    runSeq(0, 0, 2, -1, 1'b0, NP, 1'b1);

    // R7 R6: reset path after a successful start
    doReset();
    runSeq(0, 0, 3, 0, 1'b1, 1, 1'b1);
    runSeq(1, 0, 3, -1, 1'b0, NP, 1'b0);
    runSeq(1, 1, 3, 0, 1'b1, 1, 1'b0);

    // R8: stop only the named bridge
    doReset();
    runSeq(0, 0, 0, 0, 1'b1, 1, 1'b0);
    runSeq(0, 1, 0, 0, 1'b1, 1, 1'b0);
    chk("R8 both clocks on", int'(clkEn), 3);
    issue(2, 1, 0);
    chk("R8 stop bridge1 leaves bridge0", int'(clkEn), 1);

    // R10: illegal mode request dropped
    bridgeReady = 2'b11;
    issue(0, 0, 5);
    chk("R10 error raised", int'(modeErr), 1);
    chk("R10 still ready", int'(reqReady), 1);
    repeat (20) @(negedge clk);
    chk("R10 clock unchanged", int'(clkEn), 1);
    chk("R10 word unchanged", int'(ctrlWord0), 'h11);
    chk("R10 no reset pulse", int'(bridgeRst), 0);
    chk("R10 online unchanged", int'(online), 3);
    issue(1, 1, 6);
    chk("R10 reset request dropped", int'(bridgeRst), 0);
    issue(2, 0, 1);
    chk("R10 error cleared by legal request", int'(modeErr), 0);
    chk("R8 stop bridge0", int'(clkEn), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule